// File: doc/BRIEF.md
# Power-On Memory Self-Test Sequencer

This block steers a memory self-test that runs once, right after a power-on reset, and only if a one-time-programmable enable bit is set. It drives five external test engines one after another. Each engine is started with a single-cycle pulse and answers with a done level and a pass bit. The first engine checks the boot ROM against a checksum. The second runs a case built to fail, which proves that the test machinery can report a fault. Next come the SRAM march engine and the ROM signature engine, which cover every memory except the boot ROM. The last engine clears the CPU RAMs.

Every phase has its own cycle budget. A checksum failure, a pass reported by the deliberately failing case, or an expired budget ends the sequence at once. Results are kept in sticky status flags that only a power-on reset clears. Pin, watchdog and debugger resets arrive on a separate warm-reset input. A warm reset restarts the controller but never starts an engine and leaves the status untouched.

There is no data path. All pins are plain control and status levels, so there is no valid/ready flow and no back-pressure.

Top module: `post_seq_top`

## Requirements
- R1: The sequence runs only if `otp_post_en` is high at the first clock after a power-on reset. If it is low, `seq_done` rises one clock later with `stat_not_run` set, and no bit of `eng_start` is ever raised.
- R2: After a warm reset (`wrst_n` low, `por_n` high), the block raises `seq_done` one clock after release. It starts no engine and does not change any status flag.
- R3: Phase 0 (boot-ROM checksum, `eng_start[0]`) always runs first. If it reports fail, `stat_cks_fail` is set, `seq_done` rises and no other engine is started.
- R4: Phase 1 (always-fail case, `eng_start[1]`) follows a passing checksum. If it reports pass, `stat_af_err` is set, `seq_done` rises and engines 2 to 4 are never started. If it reports fail, the sequence continues.
- R5: Phase 2 (SRAM march, `eng_start[2]`) runs next, then phase 3 (ROM signature, `eng_start[3]`). A fail from either sets `stat_mem_fail`, and the sequence continues anyway.
- R6: Phase 4 (RAM clear, `eng_start[4]`) runs last, after both memory tests. Its pass bit is ignored, and `seq_done` rises one clock after its done is seen.
- R7: A start is a one-cycle pulse on exactly one bit of `eng_start`. The pulse goes out one clock after the previous phase's done is seen, or one clock after reset release for phase 0. Each engine's pass bit is read only in a cycle where its done bit is high.
- R8: A phase whose done is not seen in any of the N cycles after its start pulse is abandoned. N is that phase's timeout parameter. `stat_timeout` is set, `stat_to_phase` records the phase number (0 to 4), no further engine is started, and `seq_done` rises.
- R9: A done bit that first appears in the N-th cycle after the start pulse is accepted. Done takes priority over an expiry in that same cycle.
- R10: Status flags are sticky until the next power-on reset, which clears them all. Once high, `seq_done` stays high until the next reset of either kind, whichever path ended the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears the status |
| wrst_n | input | 1 | Warm reset (pin, watchdog, debugger), active low, asynchronous |
| otp_post_en | input | 1 | Self-test enable from one-time-programmable configuration |
| eng_start | output | 5 | One-cycle start pulse per engine, index = phase number |
| eng_done | input | 5 | Engine completion levels |
| eng_pass | input | 5 | Engine results, valid while the matching done is high |
| seq_done | output | 1 | Sequence has terminated |
| stat_not_run | output | 1 | Power-on run skipped because disabled |
| stat_cks_fail | output | 1 | Checksum failed, later phases not executed |
| stat_af_err | output | 1 | Always-fail case wrongly reported pass |
| stat_mem_fail | output | 1 | March or signature test failed |
| stat_timeout | output | 1 | A phase exceeded its budget |
| stat_to_phase | output | 3 | Number of the phase that timed out |

## Verification
The assertions rely on a few assumptions about the engines. An engine's done stays low until after its own start pulse. Once raised, done stays high until the next power-on reset. The pass bit counts only while done is high. The enable bit stays steady through the first clock after reset, and every timeout parameter is at least one. The bench engine models follow these rules. They raise done a set number of cycles after they see their pulse and hold it. They clear on power-on reset and drive the inverse of the real result on pass until done, so that a design reading pass early shows up. Both resets change only just after a rising edge and span whole cycles.

// File: rtl/post_seq_pkg.sv
package post_seq_pkg;

  localparam int NPH  = 5;
  localparam int PHW  = 3;

  typedef enum logic [PHW-1:0] {
    PH_CKS   = 3'd0,
    PH_AF    = 3'd1,
    PH_MARCH = 3'd2,
    PH_SIG   = 3'd3,
    PH_INIT  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_START,
    SQ_WAIT,
    SQ_DONE
  } sq_state_e;

  typedef struct packed {
    logic   not_run;
    logic   cks_fail;
    logic   af_err;
    logic   mem_fail;
    logic   timeout;
    phase_e to_phase;
  } stat_t;

  typedef struct packed {
    logic   set_not_run;
    logic   set_cks;
    logic   set_af;
    logic   set_mem;
    logic   set_to;
    phase_e ph;
  } stat_upd_t;

endpackage

// File: rtl/post_phase_timer.sv
module post_phase_timer
  import post_seq_pkg::*;
#(
  parameter int unsigned TMO_CKS   = 4096,
  parameter int unsigned TMO_AF    = 256,
  parameter int unsigned TMO_MARCH = 65536,
  parameter int unsigned TMO_SIG   = 16384,
  parameter int unsigned TMO_INIT  = 8192
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   run,
  input  phase_e ph,
  output logic   expired
);

  localparam int unsigned M01  = (TMO_CKS > TMO_AF) ? TMO_CKS : TMO_AF;
  localparam int unsigned M23  = (TMO_MARCH > TMO_SIG) ? TMO_MARCH : TMO_SIG;
  localparam int unsigned M03  = (M01 > M23) ? M01 : M23;
  localparam int unsigned MAXL = (M03 > TMO_INIT) ? M03 : TMO_INIT;
  localparam int          CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    unique case (ph)
      PH_CKS:   lim = CW'(TMO_CKS);
      PH_AF:    lim = CW'(TMO_AF);
      PH_MARCH: lim = CW'(TMO_MARCH);
      PH_SIG:   lim = CW'(TMO_SIG);
      default:  lim = CW'(TMO_INIT);
    endcase
  end

  assign expired = run && (cnt == lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (run && !expired) begin
      cnt <= cnt + CW'(1);
    end
  end

  AST_TMR_IN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < lim)); // R8

  AST_TMR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R8

endmodule

// File: rtl/post_start_dec.sv
module post_start_dec
  import post_seq_pkg::*;
(
  input  logic           fire,
  input  phase_e         ph,
  output logic [NPH-1:0] start
);

  for (genvar g = 0; g < NPH; g++) begin : g_start
    assign start[g] = fire && (ph == phase_e'(g));
  end

endmodule

// File: rtl/post_status_regs.sv
module post_status_regs
  import post_seq_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  stat_upd_t upd,
  output stat_t     stat
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stat <= '0;
    end else begin
      if (upd.set_not_run) stat.not_run  <= 1'b1;
      if (upd.set_cks)     stat.cks_fail <= 1'b1;
      if (upd.set_af)      stat.af_err   <= 1'b1;
      if (upd.set_mem)     stat.mem_fail <= 1'b1;
      if (upd.set_to) begin
        stat.timeout  <= 1'b1;
        stat.to_phase <= upd.ph;
      end
    end
  end

  AST_STICKY_CKS: assert property (@(posedge clk) disable iff (!por_n)
    stat.cks_fail |=> stat.cks_fail); // R10

  AST_STICKY_MEM: assert property (@(posedge clk) disable iff (!por_n)
    stat.mem_fail |=> stat.mem_fail); // R10

  AST_STICKY_TO: assert property (@(posedge clk) disable iff (!por_n)
    stat.timeout |=> (stat.timeout && $stable(stat.to_phase))); // R8

endmodule

// File: rtl/post_seq_top.sv
module post_seq_top
  import post_seq_pkg::*;
#(
  parameter int unsigned TMO_CKS   = 4096,
  parameter int unsigned TMO_AF    = 256,
  parameter int unsigned TMO_MARCH = 65536,
  parameter int unsigned TMO_SIG   = 16384,
  parameter int unsigned TMO_INIT  = 8192
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           wrst_n,
  input  logic           otp_post_en,
  output logic [NPH-1:0] eng_start,
  input  logic [NPH-1:0] eng_done,
  input  logic [NPH-1:0] eng_pass,
  output logic           seq_done,
  output logic           stat_not_run,
  output logic           stat_cks_fail,
  output logic           stat_af_err,
  output logic           stat_mem_fail,
  output logic           stat_timeout,
  output logic [PHW-1:0] stat_to_phase
);

  logic      rst_n;
  sq_state_e state, state_n;
  phase_e    ph, ph_n;
  logic      por_pend;
  logic      expired;
  logic      done_cur, pass_cur;
  stat_upd_t upd, upd_g;
  stat_t     stat;

  assign rst_n = por_n & wrst_n;

  // pending flag: set only by power-on reset, consumed when leaving idle
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      por_pend <= 1'b1;
    end else if (rst_n && state == SQ_IDLE) begin
      por_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      ph    <= PH_CKS;
    end else begin
      state <= state_n;
      ph    <= ph_n;
    end
  end

  assign done_cur = eng_done[ph];
  assign pass_cur = eng_pass[ph];

  always_comb begin
    state_n = state;
    ph_n    = ph;
    upd     = '0;
    upd.ph  = ph;
    unique case (state)
      SQ_IDLE: begin
        if (por_pend && otp_post_en) begin
          state_n = SQ_START;
          ph_n    = PH_CKS;
        end else begin
          state_n         = SQ_DONE;
          upd.set_not_run = por_pend;
        end
      end
      SQ_START: state_n = SQ_WAIT;
      SQ_WAIT: begin
        if (done_cur) begin
          unique case (ph)
            PH_CKS: begin
              if (pass_cur) begin
                ph_n    = PH_AF;
                state_n = SQ_START;
              end else begin
                upd.set_cks = 1'b1;
                state_n     = SQ_DONE;
              end
            end
            PH_AF: begin
              if (pass_cur) begin
                upd.set_af = 1'b1;
                state_n    = SQ_DONE;
              end else begin
                ph_n    = PH_MARCH;
                state_n = SQ_START;
              end
            end
            PH_MARCH: begin
              upd.set_mem = !pass_cur;
              ph_n        = PH_SIG;
              state_n     = SQ_START;
            end
            PH_SIG: begin
              upd.set_mem = !pass_cur;
              ph_n        = PH_INIT;
              state_n     = SQ_START;
            end
            default: state_n = SQ_DONE;
          endcase
        end else if (expired) begin
          upd.set_to = 1'b1;
          state_n    = SQ_DONE;
        end
      end
      default: state_n = SQ_DONE;
    endcase
  end

  assign upd_g = rst_n ? upd : '0;

  post_phase_timer #(
    .TMO_CKS  (TMO_CKS),
    .TMO_AF   (TMO_AF),
    .TMO_MARCH(TMO_MARCH),
    .TMO_SIG  (TMO_SIG),
    .TMO_INIT (TMO_INIT)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (state == SQ_START),
    .run    (state == SQ_WAIT),
    .ph     (ph),
    .expired(expired)
  );

  post_start_dec u_dec (
    .fire (state == SQ_START),
    .ph   (ph),
    .start(eng_start)
  );

  post_status_regs u_stat (
    .clk  (clk),
    .por_n(por_n),
    .upd  (upd_g),
    .stat (stat)
  );

  assign seq_done      = (state == SQ_DONE);
  assign stat_not_run  = stat.not_run;
  assign stat_cks_fail = stat.cks_fail;
  assign stat_af_err   = stat.af_err;
  assign stat_mem_fail = stat.mem_fail;
  assign stat_timeout  = stat.timeout;
  assign stat_to_phase = stat.to_phase;

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_start)); // R7

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start != '0) |=> (eng_start == '0)); // R7

  AST_NOTRUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stat_not_run |-> (eng_start == '0)); // R1

  AST_CKS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_cks_fail |-> (eng_start[NPH-1:1] == '0)); // R3

  AST_AF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_af_err |-> (eng_start[NPH-1:2] == '0)); // R4

  AST_TO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_timeout |-> (eng_start == '0)); // R8

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> seq_done); // R10

  AST_TO_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_timeout) |-> seq_done); // R8

endmodule

// File: tb/sim_post_seq_top.sv
`timescale 1ns/1ps
module sim_post_seq_top;
  import post_seq_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por_n = 1'b0, wrst_n = 1'b1, otp = 1'b0;
  logic [4:0] eng_start, eng_pass;
  logic [4:0] done_r = '0;
  logic seq_done, s_nr, s_cks, s_af, s_mem, s_to;
  logic [2:0] s_toph;

  int lim [5] = '{8, 6, 12, 10, 8};
  int dly [5];
  bit pres[5];
  int rem [5];
  int nstart[5];
  int checks = 0, errors = 0;
  bit fin = 0;

  // behavioural model state: 0 idle, 1 start, 2 wait, 3 done
  int ms = 0, mph = 0, mcnt = 0, e_toph = 0;
  bit ppend = 1, e_nr, e_cks, e_af, e_mem, e_to, p;

  for (genvar g = 0; g < 5; g++) begin : g_pass
    assign eng_pass[g] = done_r[g] ? pres[g] : !pres[g];  // R7 garbage before done
  end

  post_seq_top #(.TMO_CKS(8), .TMO_AF(6), .TMO_MARCH(12), .TMO_SIG(10), .TMO_INIT(8)) u0 (
    .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .otp_post_en(otp),
    .eng_start(eng_start), .eng_done(done_r), .eng_pass(eng_pass),
    .seq_done(seq_done), .stat_not_run(s_nr), .stat_cks_fail(s_cks),
    .stat_af_err(s_af), .stat_mem_fail(s_mem), .stat_timeout(s_to),
    .stat_to_phase(s_toph));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!por_n) begin
      ppend = 1; e_nr = 0; e_cks = 0; e_af = 0; e_mem = 0; e_to = 0; e_toph = 0; ms = 0;
      for (int i = 0; i < 5; i++) begin rem[i] = 0; done_r[i] = 1'b0; end
    end else if (!wrst_n) begin
      ms = 0;
    end
    chk("R7 eng_start", eng_start, (ms == 1) ? (1 << mph) : 0);
    chk("R10 seq_done", seq_done, ms == 3);
    chk("R1 not_run", s_nr, e_nr);
    chk("R3 cks_fail", s_cks, e_cks);
    chk("R4 af_err", s_af, e_af);
    chk("R5 mem_fail", s_mem, e_mem);
    chk("R8 timeout", s_to, e_to);
    chk("R8 to_phase", s_toph, e_toph);
    for (int i = 0; i < 5; i++) if (eng_start[i]) nstart[i]++;
    if (por_n) begin
      for (int i = 0; i < 5; i++) begin
        if (eng_start[i]) begin rem[i] = dly[i]; done_r[i] = 1'b0; end
        else if (rem[i] > 0) begin rem[i]--; if (rem[i] == 0) done_r[i] = 1'b1; end
      end
    end
    if (por_n && wrst_n) begin
      case (ms)
        0: begin
          if (ppend && otp) begin ms = 1; mph = 0; end
          else begin if (ppend) e_nr = 1; ms = 3; end
          ppend = 0;
        end
        1: begin ms = 2; mcnt = 0; end
        2: begin
          if (done_r[mph]) begin
            p = pres[mph];
            case (mph)
              0: if (p) begin mph = 1; ms = 1; end else begin e_cks = 1; ms = 3; end
              1: if (p) begin e_af = 1; ms = 3; end else begin mph = 2; ms = 1; end
              2, 3: begin if (!p) e_mem = 1; mph++; ms = 1; end
              default: ms = 3;
            endcase
          end else if (mcnt == lim[mph] - 1) begin
            e_to = 1; e_toph = mph; ms = 3;
          end else mcnt++;
        end
        default: ;
      endcase
    end
  end

  task automatic cfg(int d0, int d1, int d2, int d3, int d4,
                     bit p0, bit p1, bit p2, bit p3, bit p4);
    dly  = '{d0, d1, d2, d3, d4};
    pres = '{p0, p1, p2, p3, p4};
  endtask

  task automatic clr_counts();
    for (int i = 0; i < 5; i++) nstart[i] = 0;
  endtask

  task automatic do_por(bit en);
    @(posedge clk); #1;
    otp = en; por_n = 1'b0; clr_counts();
    repeat (2) @(posedge clk);
    #1 por_n = 1'b1;
  endtask

  task automatic do_warm();
    @(posedge clk); #1;
    wrst_n = 1'b0; clr_counts();
    repeat (2) @(posedge clk);
    #1 wrst_n = 1'b1;
  endtask

  task automatic wait_done(string tag);
    int n = 0;
    @(negedge clk);
    while (!seq_done && n < 400) begin @(negedge clk); n++; end
    if (!seq_done) chk({tag, " seq_done reached"}, 0, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // reset state
    #3;
    chk("R10 reset seq_done", seq_done, 0);
    chk("R10 reset flags", {s_nr, s_cks, s_af, s_mem, s_to}, 0);

    // R1 disabled
    cfg(2, 2, 2, 2, 2, 1, 0, 1, 1, 1);
    do_por(0);
    wait_done("R1");
    chk("R1 not_run set", s_nr, 1);
    chk("R1 no start", nstart[0] + nstart[1] + nstart[2] + nstart[3] + nstart[4], 0);

    // clean run, each engine once in order
    do_por(1);
    wait_done("R6");
    chk("R10 not_run cleared by POR", s_nr, 0);
    chk("R3 checksum started once", nstart[0], 1);
    chk("R4 always-fail started once", nstart[1], 1);
    chk("R5 march started once", nstart[2], 1);
    chk("R5 signature started once", nstart[3], 1);
    chk("R6 ram clear started once", nstart[4], 1);
    chk("R6 clean flags", {s_cks, s_af, s_mem, s_to}, 0);

    // signature fail, ram clear pass ignored
    cfg(3, 2, 4, 5, 1, 1, 0, 1, 0, 0);
    do_por(1);
    wait_done("R5");
    chk("R5 sig fail sets mem_fail", s_mem, 1);
    chk("R6 ram clear still runs", nstart[4], 1);

    cfg(3, 2, 4, 5, 1, 1, 0, 1, 1, 0);
    do_por(1);
    wait_done("R6");
    chk("R6 ram clear pass ignored", s_mem, 0);

    // march fail then warm reset
    cfg(2, 3, 2, 2, 2, 1, 0, 0, 1, 1);
    do_por(1);
    wait_done("R5");
    chk("R5 march fail sets mem_fail", s_mem, 1);
    do_warm();
    wait_done("R2");
    chk("R2 warm reset starts nothing", nstart[0] + nstart[1] + nstart[2] + nstart[3] + nstart[4], 0);
    chk("R10 mem_fail kept over warm reset", s_mem, 1);
    chk("R2 warm reset no not_run", s_nr, 0);

    // checksum fail
    cfg(2, 2, 2, 2, 2, 0, 0, 1, 1, 1);
    do_por(1);
    wait_done("R3");
    chk("R3 cks_fail", s_cks, 1);
    chk("R3 later phases skipped", nstart[1] + nstart[2] + nstart[3] + nstart[4], 0);

    // always-fail case passes
    cfg(2, 2, 2, 2, 2, 1, 1, 1, 1, 1);
    do_por(1);
    wait_done("R4");
    chk("R4 af_err", s_af, 1);
    chk("R4 memory phases bypassed", nstart[2] + nstart[3] + nstart[4], 0);

    // march never answers
    cfg(2, 2, 0, 2, 2, 1, 0, 1, 1, 1);
    do_por(1);
    wait_done("R8");
    chk("R8 timeout set", s_to, 1);
    chk("R8 phase code march", s_toph, 2);
    chk("R8 ram clear not started", nstart[4], 0);

    // boundary: done exactly at budget accepted, one later times out
    cfg(8, 6, 12, 11, 1, 1, 0, 1, 1, 1);
    do_por(1);
    wait_done("R9");
    chk("R9 march at limit accepted", nstart[3], 1);
    chk("R9 signature past limit", s_toph, 3);
    chk("R9 timeout flag", s_to, 1);

    // checksum one past budget
    cfg(9, 2, 2, 2, 2, 1, 0, 1, 1, 1);
    do_por(1);
    wait_done("R8");
    chk("R8 phase code checksum", s_toph, 0);
    chk("R8 no always-fail start", nstart[1], 0);

    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule